// File: doc/BRIEF.md
# Transmit Deferral and Interframe Gap Timer

This block decides the clock cycle in which a half-duplex Ethernet transmitter is allowed to begin a frame. It counts the interframe gap on a four-bit-wide data path, so one clock stands for four bit-times. The full gap of 96 bit-times is 24 clocks. The gap starts when the block's own transmission ends, or when carrier sense falls. Carrier sense is watched only during the first 16 clocks (64 bit-times) of that gap. If carrier returns inside that window, the gap is thrown away and started again once the line is quiet. If carrier returns after the window, it is ignored and the gap runs to the end.

A transmit request is a one-clock strobe. The block holds the request until the gap allows it and then answers with a single one-cycle grant. A retransmit flag from the backoff logic rises once backoff has expired. That rising edge forces the block to wait for an idle line and then time a fresh full gap before the retried frame may start. Backoff timing, serialization and collision detection live in other blocks.

Top module: `gap_deferral_timer`

## Requirements
- R1: While reset is asserted, txGrant is low. After reset the block defers. The first clock edge that samples carrierSense low starts a gap, and a pending request is granted 24 edges later.
- R2: If txDone is sampled high at edge 0 and nothing disturbs the gap, a request that is already pending is granted with txGrant high after edge 24 and not before.
- R3: txGrant is high for exactly one cycle per pending request. Several request strobes that arrive before the grant merge into one grant. After a grant, no further grant occurs until a new txDone has been followed by a complete gap.
- R4: A request that arrives during the gap is held until the gap ends. A request sampled at edge N after the gap has completed, with carrier low, makes txGrant high after edge N.
- R5: If carrierSense is sampled high at any of edges 1 to 16 after the gap starts, the gap is abandoned. The next edge that samples carrierSense low starts a new gap, and the grant follows 24 edges later.
- R6: carrierSense sampled high at edges 17 to 24 of the gap has no effect, and the grant still comes after edge 24.
- R7: After the gap has completed, carrierSense sampled high blocks the grant on that edge. A full new gap is then timed from the edge where carrier is next sampled low.
- R8: A low-to-high change on retxFlag, seen while a gap is running or has completed, discards that gap and takes priority over a grant on the same edge. A new gap starts at the next edge that samples carrierSense low.
- R9: txDone restarts the gap from zero in every state and takes priority over carrier sense and retxFlag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble clock (one clock = four bit-times) |
| rstN | input | 1 | Asynchronous active-low reset |
| carrierSense | input | 1 | Line activity indication |
| txRequest | input | 1 | One-clock strobe asking to start a frame |
| retxFlag | input | 1 | Raised by backoff logic when a retry may proceed |
| txDone | input | 1 | One-clock pulse at the end of the local transmission |
| txGrant | output | 1 | One-clock permission to start the frame |

## Verification
A gap counter that is off by even one value moves the grant by whole clocks against the expected edge. This shows within 24 clocks of every txDone or carrier drop. A sensing window that is too wide or too narrow shows only when carrier returns near clock 16 of the gap. The sweeps therefore place a carrier burst at every gap offset. A stuck request latch or a lost retransmit edge shows as a missing, extra or late grant in the same scenario that caused it. Each scenario counts grants over 70 clocks, not only at the expected edge.

// File: rtl/gap_timer_pkg.sv
package gap_timer_pkg;

  typedef enum logic [1:0] {
    ST_DEFER = 2'd0,  // waiting for an idle line before timing a gap
    ST_GAP   = 2'd1,  // interframe gap being counted
    ST_READY = 2'd2,  // gap satisfied, waiting for a request
    ST_SEND  = 2'd3   // frame granted, waiting for end of transmission
  } deferState_t;

  typedef struct packed {
    logic gapClear;  // restart the gap count at zero
    logic gapInc;    // advance the gap count
    logic fire;      // issue a grant and consume the request
  } gapCtl_t;

endpackage

// File: rtl/ifg_datapath.sv
module ifg_datapath
  import gap_timer_pkg::*;
#(
  parameter int GAP_CLKS   = 24,
  parameter int SENSE_CLKS = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  gapCtl_t ctl,
  input  logic    txRequest,
  input  logic    retxFlag,
  output logic    senseOpen,
  output logic    gapDone,
  output logic    pending,
  output logic    retxRise,
  output logic    txGrant
);

  localparam int CNT_W = (GAP_CLKS > 1) ? $clog2(GAP_CLKS) : 1;
  localparam logic [CNT_W-1:0] SENSE_LIM = CNT_W'(SENSE_CLKS);
  localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(GAP_CLKS - 1);

  logic [CNT_W-1:0] gapCnt;
  logic             pendQ;
  logic             retxPrev;
  logic             grantQ;

  // Gap counter: cleared on a gap start, advanced by the control.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt <= '0;
    end else if (ctl.gapClear) begin
      gapCnt <= '0;
    end else if (ctl.gapInc) begin
      gapCnt <= gapCnt + CNT_W'(1);
    end
  end

  assign senseOpen = (gapCnt < SENSE_LIM);
  assign gapDone   = (gapCnt == LAST_CNT);

  // Request latch: a strobe is remembered until a grant consumes it.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= 1'b0;
    end else if (ctl.fire) begin
      pendQ <= 1'b0;
    end else if (txRequest) begin
      pendQ <= 1'b1;
    end
  end

  assign pending = pendQ | txRequest;

  // Edge detector on the retransmit flag.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      retxPrev <= 1'b0;
    end else begin
      retxPrev <= retxFlag;
    end
  end

  assign retxRise = retxFlag & ~retxPrev;

  // Registered grant output.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantQ <= 1'b0;
    end else begin
      grantQ <= ctl.fire;
    end
  end

  assign txGrant = grantQ;

  AST_GRANT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    txGrant |=> !txGrant);  // R3

  AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    txGrant |-> $past(pending));  // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    ctl.gapInc |-> !gapDone);  // R2

endmodule

// File: rtl/ifg_control.sv
module ifg_control
  import gap_timer_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    carrierSense,
  input  logic    txDone,
  input  logic    senseOpen,
  input  logic    gapDone,
  input  logic    pending,
  input  logic    retxRise,
  output gapCtl_t ctl
);

  deferState_t state;
  deferState_t stateNxt;

  always_comb begin
    stateNxt = state;
    ctl      = '0;
    if (txDone) begin
      stateNxt     = ST_GAP;
      ctl.gapClear = 1'b1;
    end else begin
      unique case (state)
        ST_DEFER: begin
          if (!carrierSense) begin
            stateNxt     = ST_GAP;
            ctl.gapClear = 1'b1;
          end
        end
        ST_GAP: begin
          if (retxRise || (senseOpen && carrierSense)) begin
            stateNxt = ST_DEFER;
          end else if (gapDone) begin
            if (pending) begin
              ctl.fire = 1'b1;
              stateNxt = ST_SEND;
            end else begin
              stateNxt = ST_READY;
            end
          end else begin
            ctl.gapInc = 1'b1;
          end
        end
        ST_READY: begin
          if (retxRise || carrierSense) begin
            stateNxt = ST_DEFER;
          end else if (pending) begin
            ctl.fire = 1'b1;
            stateNxt = ST_SEND;
          end
        end
        ST_SEND: begin
          stateNxt = ST_SEND;
        end
        default: stateNxt = ST_DEFER;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_DEFER;
    end else begin
      state <= stateNxt;
    end
  end

  AST_EARLY_CARRIER_DEFERS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_GAP && senseOpen && carrierSense && !txDone) |=> (state == ST_DEFER));  // R5

  AST_LATE_CARRIER_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_GAP && !senseOpen && carrierSense && !txDone && !retxRise && !gapDone)
      |=> (state == ST_GAP));  // R6

  AST_BUSY_BLOCKS_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_READY && carrierSense) |-> !ctl.fire);  // R7

  AST_RETX_BEATS_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    (retxRise && !txDone && (state == ST_GAP || state == ST_READY)) |-> !ctl.fire);  // R8

  AST_DONE_STARTS_GAP: assert property (@(posedge clk) disable iff (!rstN)
    txDone |=> (state == ST_GAP));  // R9

endmodule

// File: rtl/gap_deferral_timer.sv
module gap_deferral_timer
  import gap_timer_pkg::*;
#(
  parameter int GAP_CLKS   = 24,
  parameter int SENSE_CLKS = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic carrierSense,
  input  logic txRequest,
  input  logic retxFlag,
  input  logic txDone,
  output logic txGrant
);

  gapCtl_t ctl;
  logic    senseOpen;
  logic    gapDone;
  logic    pending;
  logic    retxRise;

  ifg_control u_control (
    .clk          (clk),
    .rstN         (rstN),
    .carrierSense (carrierSense),
    .txDone       (txDone),
    .senseOpen    (senseOpen),
    .gapDone      (gapDone),
    .pending      (pending),
    .retxRise     (retxRise),
    .ctl          (ctl)
  );

  ifg_datapath #(
    .GAP_CLKS   (GAP_CLKS),
    .SENSE_CLKS (SENSE_CLKS)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .txRequest (txRequest),
    .retxFlag  (retxFlag),
    .senseOpen (senseOpen),
    .gapDone   (gapDone),
    .pending   (pending),
    .retxRise  (retxRise),
    .txGrant   (txGrant)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) !rstN |-> !txGrant);  // R1

endmodule

// File: tb/tb_gap_deferral_timer.sv
module tb_gap_deferral_timer;

  localparam int GAP   = 24;
  localparam int SENSE = 16;
  localparam int RUN   = 70;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cs = 1'b1;
  logic req = 1'b0;
  logic retx = 1'b0;
  logic done = 1'b0;
  logic txGrant;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  gap_deferral_timer #(.GAP_CLKS(GAP), .SENSE_CLKS(SENSE)) dut (
    .clk          (clk),
    .rstN         (rstN),
    .carrierSense (cs),
    .txRequest    (req),
    .retxFlag     (retx),
    .txDone       (done),
    .txGrant      (txGrant)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic step(input logic c, input logic r, input logic x, input logic d);
    @(negedge clk);
    cs = c; req = r; retx = x; done = d;
    @(posedge clk);
    #1;
  endtask

  // mode 0: carrier burst at a, length b (R5/R6)
  // mode 1: request at a (R4)   mode 2: retx rise at a (R8)
  // mode 3: carrier in ready at a, length b (R7)   mode 4: second txDone at a (R9)
  // mode 5: merged requests (R3)   mode 6: first gap after reset (R1)
  task automatic runCase(input int mode, input int a, input int b, input int expStep, input string tag);
    int first = -1;
    int count = 0;
    for (int s = 0; s < RUN; s++) begin
      logic c, r, x, d;
      c = 1'b0; r = 1'b0; x = 1'b0; d = 1'b0;
      case (mode)
        0: begin d = (s == 0); r = (s == 0); c = (s >= a && s < a + b); end
        1: begin d = (s == 0); r = (s == a); end
        2: begin d = (s == 0); r = (s == 0); x = (s >= a); end
        3: begin d = (s == 0); r = (s == 30); c = (s >= a && s < a + b); end
        4: begin d = (s == 0 || s == a); r = (s == 0); end
        5: begin d = (s == 0); r = (s == 3 || s == 7 || s == 12); end
        default: begin r = (s == 0); end
      endcase
      step(c, r, x, d);
      if (txGrant) begin
        count++;
        if (first < 0) first = s;
      end
    end
    checks++;
    if (count != 1 || first != expStep) begin
      fails++;
      $display("FAIL %s: grant at step %0d (count %0d), expected step %0d (count 1)",
               tag, first, count, expStep);
    end
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (txGrant !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: txGrant=%b expected 0", txGrant);
    end
    @(negedge clk);
    rstN = 1'b1;

    // R1: carrier held high through release, first quiet edge is step 0
    runCase(6, 0, 0, GAP, "R1 first gap after reset");

    // R5 / R6: carrier burst at every gap offset
    for (int k = 1; k <= GAP; k++) begin
      for (int len = 1; len <= 3; len += 2) begin
        int e;
        e = (k <= SENSE) ? k + len + GAP : GAP;
        runCase(0, k, len, e, $sformatf("%s carrier at %0d len %0d", (k <= SENSE) ? "R5" : "R6", k, len));
      end
    end

    // R2 / R4: request at every step through and past the gap
    for (int a = 0; a <= 40; a++) begin
      runCase(1, a, 0, (a < GAP) ? GAP : a,
              $sformatf("%s request at %0d", (a == 0) ? "R2" : "R4", a));
    end

    // R8: retransmit flag rising at every gap offset
    for (int a = 1; a <= GAP; a++) begin
      runCase(2, a, 0, a + 1 + GAP, $sformatf("R8 retx rise at %0d", a));
    end

    // R7: carrier after the gap completed
    for (int a = GAP + 1; a <= 30; a++) begin
      runCase(3, a, 2, a + 2 + GAP, $sformatf("R7 ready carrier at %0d", a));
    end

    // R9: second txDone at various offsets
    for (int a = 1; a <= 30; a++) begin
      runCase(4, a, 0, (a <= GAP) ? a + GAP : GAP, $sformatf("R9 txDone again at %0d", a));
    end

    // R3: merged requests give one grant, none afterwards
    runCase(5, 0, 0, GAP, "R3 merged requests");

    summary();
    $finish;
  end

endmodule